// File: doc/BRIEF.md
# PC Card configuration register file

This block holds the two configuration registers that a 16-bit PC Card exposes in its attribute memory. The host reaches them with attribute-space reads and writes at byte addresses 800h (option register) and 802h (configuration and status register). The card's configuration table therefore names 800h as its register base, and the status register sits two bytes above it. Each write takes one clock. A read returns its data combinationally while the access is active.

The option register drives the card's internal state. It carries a sticky soft-reset bit, which is combined with the external card reset. It also carries the interrupt signalling mode and the configuration index, and a nonzero index turns the I/O interface on. The status register carries two plain storage bits. It also has a wakeup bit that combines with a firmware data bit to build the status-change pin, and a power-down request with a confirmation handshake to an embedded controller.

The interrupt shaper turns an internal request into the host interrupt. In pulse mode, every rising edge of the request gives a pulse of fixed width. In level mode, the output follows the request.

Top module: `pccfg_regfile`

## Requirements
- R1: A write takes effect at the clock edge only when `reg_sel`, `ce` and `we` are all 1. At address 800h the write stores `wdata` into the option register. At address 802h it stores bits 5, 4, 3 and 2 into the status register. Writes to any other address, or with any strobe low, change nothing.
- R2: While `reg_sel`=1, `ce`=1 and `we`=0, `rdata` is the option register at 800h and the status image at 802h. At every other address (odd addresses included), and whenever the read strobes are not all active, `rdata` is 00h.
- R3: Option bit 7 is the soft reset. `dev_rst` is 1 while this bit is 1 or `rst_ext` is 1. The bit keeps its value until a host write changes it.
- R4: Option bit 6 drives `lvl_mode` (1 = level interrupts, 0 = pulse interrupts).
- R5: Option bits 5:0 are the configuration index. `io_en` is 1 exactly when the index is nonzero.
- R6: In the status image, bits 7, 6, 1 and 0 always read 0.
- R7: Status bit 5 (8-bit I/O flag) and status bit 3 (scratch) read back what was written and affect no output.
- R8: Status bit 4 is the wakeup bit. When `chg_fn_sel`=1, `chg_pin` = NOT(wakeup AND `fw_chg_bit`). When `chg_fn_sel`=0, `chg_pin` = `fw_chg_bit`.
- R9: Writing status bit 2 sets `pd_req` to the written value. Status bit 2 reads as `pd_req` AND `pd_entered`, so it reads 0 until the controller confirms power down.
- R10: `rst_ext`=1 clears every register bit to 0 at the next clock edge.
- R11: In pulse mode, each rising edge of `irq_req` sampled at a clock edge drives `irq_o` high for exactly PULSE_W cycles, starting right after that edge. An edge that arrives during a pulse restarts the count.
- R12: In level mode, `irq_o` equals `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext | input | 1 | External card reset, active high, synchronous |
| reg_sel | input | 1 | Attribute-space select |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable |
| addr | input | ADDR_W | Attribute byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_req | input | 1 | Internal interrupt request |
| fw_chg_bit | input | 1 | Firmware status-change data bit |
| chg_fn_sel | input | 1 | Status-change pin function select |
| pd_entered | input | 1 | Controller confirms power down |
| dev_rst | output | 1 | Internal device reset |
| io_en | output | 1 | I/O interface enabled |
| lvl_mode | output | 1 | Interrupt mode, 1 = level |
| irq_o | output | 1 | Shaped host interrupt |
| chg_pin | output | 1 | Status-change pin value |
| pd_req | output | 1 | Power-down request to controller |

## Verification
The assertions rely on two assumptions about the inputs. First, `rst_ext` is held for at least one clock edge before the first checked cycle. Second, `irq_req` is low while reset is active, so a request edge is never lost inside reset. The pulse check also assumes the mode bit does not flip in the cycle after an edge, and it excuses that cycle whenever level mode is selected. The stimulus always starts with a held reset and keeps `irq_req` at 0 during every reset. It changes inputs only on the falling clock edge. In the random phase, addresses are drawn from the two register addresses, their odd neighbours and a few unrelated locations.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;

   typedef struct packed {
      logic io8;
      logic wake;
      logic scratch;
      logic pdreq;
   } stat_t;

   // status image: reserved bits forced to zero, power-down gated by confirm
   function automatic logic [7:0] stat_image(stat_t s, logic pd_ok);
      stat_image = {2'b00, s.io8, s.wake, s.scratch, s.pdreq & pd_ok, 2'b00};
   endfunction

endpackage

// File: rtl/pccfg_decode.sv
module pccfg_decode #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OPT_ADDR = 32'h800
) (
   input  logic              reg_sel,
   input  logic              ce,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_opt,
   output logic              wr_stat,
   output logic              rd_opt,
   output logic              rd_stat
);
   localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OPT_ADDR + 2);

   generate
      if (OPT_ADDR % 2 != 0) begin : g_bad_align
         $error("OPT_ADDR must be even");
      end
      if (OPT_ADDR + 2 >= (64'd1 << ADDR_W)) begin : g_bad_range
         $error("register window does not fit ADDR_W");
      end
   endgenerate

   logic acc_wr, acc_rd;

   always_comb begin
      acc_wr  = reg_sel & ce & we;
      acc_rd  = reg_sel & ce & ~we;
      wr_opt  = acc_wr & (addr == OPT_A);
      wr_stat = acc_wr & (addr == STAT_A);
      rd_opt  = acc_rd & (addr == OPT_A);
      rd_stat = acc_rd & (addr == STAT_A);
   end

endmodule

// File: rtl/pccfg_irq_shaper.sv
module pccfg_irq_shaper #(
   parameter int unsigned PULSE_W = 4
) (
   input  logic clk,
   input  logic rst_ext,
   input  logic lvl,
   input  logic req,
   output logic irq
);
   localparam int unsigned CNT_W = $clog2(PULSE_W + 1);

   generate
      if (PULSE_W < 1) begin : g_bad_width
         $error("PULSE_W must be at least 1");
      end
   endgenerate

   logic req_d;
   logic rise;
   logic pulse;

   assign rise = req & ~req_d;

   always_ff @(posedge clk) begin
      if (rst_ext) req_d <= 1'b0;
      else         req_d <= req;
   end

   generate
      if (PULSE_W == 1) begin : g_single
         logic p_q;
         always_ff @(posedge clk) begin
            if (rst_ext) p_q <= 1'b0;
            else         p_q <= rise;
         end
         assign pulse = p_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst_ext)             cnt_q <= '0;
            else if (rise)           cnt_q <= CNT_W'(PULSE_W);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign pulse = (cnt_q != '0);
      end
   endgenerate

   assign irq = lvl ? req : pulse;

   // R11
   pulse_start_chk: assert property (@(posedge clk) disable iff (rst_ext)
      (!lvl && $rose(req)) |=> (irq || lvl));

endmodule

// File: rtl/pccfg_regfile.sv
module pccfg_regfile
   import pccfg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OPT_ADDR = 32'h800,
   parameter int unsigned PULSE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_ext,
   input  logic              reg_sel,
   input  logic              ce,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              irq_req,
   input  logic              fw_chg_bit,
   input  logic              chg_fn_sel,
   input  logic              pd_entered,
   output logic              dev_rst,
   output logic              io_en,
   output logic              lvl_mode,
   output logic              irq_o,
   output logic              chg_pin,
   output logic              pd_req
);
   logic        wr_opt, wr_stat, rd_opt, rd_stat;
   logic [7:0]  opt_q;
   stat_t       stat_q;

   pccfg_decode #(.ADDR_W(ADDR_W), .OPT_ADDR(OPT_ADDR)) u_dec (
      .reg_sel (reg_sel),
      .ce      (ce),
      .we      (we),
      .addr    (addr),
      .wr_opt  (wr_opt),
      .wr_stat (wr_stat),
      .rd_opt  (rd_opt),
      .rd_stat (rd_stat)
   );

   always_ff @(posedge clk) begin
      if (rst_ext) begin
         opt_q  <= 8'h00;
         stat_q <= '0;
      end else begin
         if (wr_opt) opt_q <= wdata;
         if (wr_stat) begin
            stat_q.io8     <= wdata[5];
            stat_q.wake    <= wdata[4];
            stat_q.scratch <= wdata[3];
            stat_q.pdreq   <= wdata[2];
         end
      end
   end

   always_comb begin
      if (rd_opt)       rdata = opt_q;
      else if (rd_stat) rdata = stat_image(stat_q, pd_entered);
      else              rdata = 8'h00;
   end

   assign dev_rst  = rst_ext | opt_q[7];
   assign lvl_mode = opt_q[6];
   assign io_en    = |opt_q[5:0];
   assign pd_req   = stat_q.pdreq;
   assign chg_pin  = chg_fn_sel ? ~(stat_q.wake & fw_chg_bit) : fw_chg_bit;

   pccfg_irq_shaper #(.PULSE_W(PULSE_W)) u_irq (
      .clk     (clk),
      .rst_ext (rst_ext),
      .lvl     (opt_q[6]),
      .req     (irq_req),
      .irq     (irq_o)
   );

   // R3
   srst_hold_chk: assert property (@(posedge clk) disable iff (rst_ext)
      !wr_opt |=> $stable(dev_rst));

   // R6
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst_ext)
      rd_stat |-> (rdata[7:6] == 2'b00 && rdata[1:0] == 2'b00));

   // R9
   pd_gate_chk: assert property (@(posedge clk) disable iff (rst_ext)
      (rd_stat && !pd_req) |-> !rdata[2]);

   // R2
   odd_read_chk: assert property (@(posedge clk) disable iff (rst_ext)
      (reg_sel && ce && !we && addr[0]) |-> (rdata == 8'h00));

   // R8
   chg_idle_chk: assert property (@(posedge clk) disable iff (rst_ext)
      (chg_fn_sel && !fw_chg_bit) |-> chg_pin);

endmodule

// File: tb/pccfg_regfile_tb_top.sv
module pccfg_regfile_tb_top;
   localparam int PW = 4;
   localparam logic [11:0] OPT  = 12'h800;
   localparam logic [11:0] STAT = 12'h802;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_ext = 1'b1, reg_sel = 1'b0, ce = 1'b0, we = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic irq_req = 1'b0, fw_chg_bit = 1'b0, chg_fn_sel = 1'b0, pd_entered = 1'b0;
   logic [7:0] rdata;
   logic dev_rst, io_en, lvl_mode, irq_o, chg_pin, pd_req;

   pccfg_regfile #(.ADDR_W(12), .OPT_ADDR(32'h800), .PULSE_W(PW)) dut_i (
      .clk(clk), .rst_ext(rst_ext), .reg_sel(reg_sel), .ce(ce), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
      .fw_chg_bit(fw_chg_bit), .chg_fn_sel(chg_fn_sel), .pd_entered(pd_entered),
      .dev_rst(dev_rst), .io_en(io_en), .lvl_mode(lvl_mode), .irq_o(irq_o),
      .chg_pin(chg_pin), .pd_req(pd_req));

   // reference model state
   logic [7:0] m_opt = '0;
   bit m_io8, m_wake, m_scr, m_pd, m_prev;
   int m_cnt;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [7:0] e_rd;
      bit e_irq, e_chg;
      e_rd = 8'h00;
      if (reg_sel && ce && !we) begin
         if (addr == OPT)       e_rd = m_opt;
         else if (addr == STAT) e_rd = {2'b00, m_io8, m_wake, m_scr, m_pd & pd_entered, 2'b00};
      end
      e_irq = m_opt[6] ? irq_req : (m_cnt != 0);
      e_chg = chg_fn_sel ? !(m_wake && fw_chg_bit) : fw_chg_bit;
      chk("R1 R2 R6 R7 R9 rdata", rdata, e_rd);
      chk("R3 dev_rst", {7'd0, dev_rst}, {7'd0, rst_ext | m_opt[7]});
      chk("R4 lvl_mode", {7'd0, lvl_mode}, {7'd0, m_opt[6]});
      chk("R5 io_en", {7'd0, io_en}, {7'd0, (m_opt[5:0] != 0)});
      chk("R11 R12 irq_o", {7'd0, irq_o}, {7'd0, e_irq});
      chk("R8 chg_pin", {7'd0, chg_pin}, {7'd0, e_chg});
      chk("R9 pd_req", {7'd0, pd_req}, {7'd0, m_pd});
   endtask

   // one cycle: inputs already set at negedge
   task automatic cyc();
      #1 compare();
      @(posedge clk);
      if (rst_ext) begin
         m_opt = 0; m_io8 = 0; m_wake = 0; m_scr = 0; m_pd = 0; m_prev = 0; m_cnt = 0;
      end else begin
         if (reg_sel && ce && we && addr == OPT) m_opt = wdata;
         if (reg_sel && ce && we && addr == STAT) begin
            m_io8 = wdata[5]; m_wake = wdata[4]; m_scr = wdata[3]; m_pd = wdata[2];
         end
         if (irq_req && !m_prev) m_cnt = PW;
         else if (m_cnt > 0)     m_cnt--;
         m_prev = irq_req;
      end
      @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [7:0] d, logic sel = 1'b1);
      reg_sel = sel; ce = 1'b1; we = 1'b1; addr = a; wdata = d;
      cyc();
      reg_sel = 1'b0; ce = 1'b0; we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a);
      reg_sel = 1'b1; ce = 1'b1; we = 1'b0; addr = a;
      cyc();
      reg_sel = 1'b0; ce = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      #600000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      idle(3);                         // R10 reset state
      rst_ext = 1'b0;
      rd(OPT); rd(STAT);
      wr(OPT, 8'h41); rd(OPT);         // R4 R5
      wr(OPT + 12'd1, 8'hFF); rd(OPT); // R1 odd address ignored
      wr(12'h804, 8'hFF); rd(12'h804); // R1 R2
      wr(OPT, 8'hC0, 1'b0); rd(OPT);   // R1 no select
      wr(STAT, 8'hFF); rd(STAT);       // R6 R7
      pd_entered = 1'b1; rd(STAT);     // R9 confirmed
      pd_entered = 1'b0;
      wr(STAT, 8'h10);
      chg_fn_sel = 1'b1; fw_chg_bit = 1'b1; idle(1);  // R8
      fw_chg_bit = 1'b0; idle(1);
      chg_fn_sel = 1'b0; fw_chg_bit = 1'b1; idle(1);
      wr(OPT, 8'h80); idle(3);         // R3 sticky
      wr(OPT, 8'h00); idle(1);
      irq_req = 1'b1; idle(2); irq_req = 1'b0; idle(PW + 2);  // R11
      irq_req = 1'b1; idle(1); irq_req = 1'b0; idle(1);
      irq_req = 1'b1; idle(1); irq_req = 1'b0; idle(PW + 2);  // R11 restart
      wr(OPT, 8'h40);
      irq_req = 1'b1; idle(3); irq_req = 1'b0; idle(2);       // R12
      wr(STAT, 8'h3C); wr(OPT, 8'hBF);
      irq_req = 1'b0; rst_ext = 1'b1; idle(2); rst_ext = 1'b0; // R10
      rd(OPT); rd(STAT);
      for (int i = 0; i < 2000; i++) begin
         logic [11:0] al [6];
         al = '{OPT, STAT, OPT + 12'd1, STAT + 12'd1, 12'h804, 12'h000};
         reg_sel = 1'($urandom); ce = 1'($urandom); we = 1'($urandom);
         addr = al[$urandom % 6]; wdata = 8'($urandom);
         irq_req = 1'($urandom); fw_chg_bit = 1'($urandom);
         chg_fn_sel = 1'($urandom); pd_entered = 1'($urandom);
         cyc();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule